// File: doc/BRIEF.md
# Host Register Decoder with Paged Overlay and Two Personalities

This block sits between a host CPU and the protocol engines of a bus controller. The host addresses the block through a 3-bit register select, an active-low chip select, active-low read and write strobes, and an active-low DMA acknowledge. Through these it reaches:

- a received-data register and a transmit-data register;
- three interrupt status registers, each with its own mask;
- a control readback register;
- an auxiliary command port;
- one general-purpose extension register.

The protocol engines attach through plain ports. They provide per-bit status event pulses and a received byte with a load strobe. They receive the transmit byte with a one-cycle load pulse.

An auxiliary page-in command places an extra register at offset 2, in place of the normal status/mask pair there. The block has two personalities, A and B, and they differ in how long this overlay lasts.

- In personality A, which is active after reset, the overlay is withdrawn at the end of the next chip-selected host access.
- In personality B, the overlay stays until a different page-in command or a reset. Personality B also maps the extension register at offset 6, which is otherwise unused.

Status bits are static. A read never clears them. Only an explicit clear command or reset clears them. The interrupt output is high whenever any status bit is set while its mask bit is set.

All strobes are sampled on the block clock. A host access ends on the first clock edge at which its strobe is seen inactive. Writes, commands and page-out all take effect on that edge.

Top module: `hostreg_decoder`

## Requirements
- R1: After reset:
  - all status, mask, data and extension registers are zero;
  - personality A is active and no overlay is shown;
  - `int_o` and `tx_load_o` are low;
  - offset 3 (control readback: bit 0 = personality B, bit 1 = overlay shown) reads 0x00.
- R2: A chip-selected write to offset 0 sets `tx_data_o` to the written byte and raises `tx_load_o` for exactly one cycle. A write to offset 1 loads mask 0. A write to offset 2 without an overlay loads mask 1. Reads of offsets 0, 1 and 2 without an overlay return received data, status 0 and status 1. `dout` is zero when no read is active.
- R3: A status bit is set by its event pulse (`evt_i` bit 8*k+b sets status k bit b). Reading it does not clear it. The auxiliary command 0b100_kk_bbb clears status k bit b. When an event and a clear hit the same bit together, the event wins.
- R4: `int_o` is high exactly when some status bit and the same mask bit are both set.
- R5: DMA acknowledge low takes priority over chip select and register select. A read returns the received-data register. A write loads the transmit register and pulses `tx_load_o`. A DMA access does not end an overlay.
- R6: The auxiliary command 0x40 | s (a write to offset 5) shows an overlay at offset 2. With s=0 the overlay is status 2 on read and mask 2 on write. With s=1 it is the extension register for both read and write.
- R7: In personality A, the overlay is withdrawn at the end of the next chip-selected access, unless that access is itself a page-in command.
- R8: In personality B, the overlay persists across any number of accesses. A later page-in command replaces the overlay's selection. Reset returns the block to personality A with no overlay.
- R9: In personality B, offset 6 reads and writes the extension register. In personality A, offset 6 reads zero and writes to it are ignored.
- R10: The auxiliary command 0x20 selects personality A and 0x21 selects personality B. Either command withdraws any overlay.
- R11: Offsets 4 and 7 read zero, and so does offset 5 (the command port).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dack_n | input | 1 | DMA acknowledge, active low |
| rs | input | AW | Register select |
| din | input | DW | Host write data |
| dout | output | DW | Host read data |
| int_o | output | 1 | Interrupt request |
| evt_i | input | 3*DW | Status set pulses from the engines |
| rx_data_i | input | DW | Byte received by an engine |
| rx_load_i | input | 1 | Load strobe for `rx_data_i` |
| tx_data_o | output | DW | Transmit register contents |
| tx_load_o | output | 1 | One-cycle pulse after a transmit register write |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and a 3-bit select. With these values the full command encoding is reachable, including clears addressed to the nonexistent fourth status register. All eight offsets are reachable too, so the unassigned offsets and the personality-dependent offset 6 can be read and written directly. Every overlay lifetime case is driven from the ports:

- an overlay consumed by a read;
- an overlay consumed by a write;
- an overlay that survives an intervening DMA access;
- an overlay that persists in personality B;
- an overlay cleared by reset.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
  localparam int NSTAT = 3;

  typedef enum logic {
    MODE_A = 1'b0,
    MODE_B = 1'b1
  } mode_e;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_ST0  = 3'd1;
  localparam logic [2:0] OFF_ST1  = 3'd2;
  localparam logic [2:0] OFF_CTRL = 3'd3;
  localparam logic [2:0] OFF_AUX  = 3'd5;
  localparam logic [2:0] OFF_EXT  = 3'd6;

  localparam logic [2:0] OP_MODE = 3'b001;
  localparam logic [2:0] OP_PAGE = 3'b010;
  localparam logic [2:0] OP_CLR  = 3'b100;
endpackage

// File: rtl/hrd_strobe.sv
module hrd_strobe #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          dack_n,
  input  logic [AW-1:0] rs,
  input  logic [DW-1:0] din,
  output logic          end_o,
  output logic          wr_o,
  output logic          dma_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          act, act_q, act_d;
  logic [AW-1:0] a_q, a_d;
  logic [DW-1:0] d_q, d_d;
  logic          w_q, w_d, m_q, m_d;

  always_comb begin
    act   = (~cs_n | ~dack_n) & (~rd_n | ~wr_n);
    act_d = act;
    a_d   = rs;
    d_d   = din;
    w_d   = ~wr_n;
    m_d   = ~dack_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      a_q   <= '0;
      d_q   <= '0;
      w_q   <= 1'b0;
      m_q   <= 1'b0;
    end else begin
      act_q <= act_d;
      if (act) begin
        a_q <= a_d;
        d_q <= d_d;
        w_q <= w_d;
        m_q <= m_d;
      end
    end
  end

  assign end_o  = act_q & ~act;
  assign wr_o   = w_q;
  assign dma_o  = m_q;
  assign addr_o = a_q;
  assign data_o = d_q;
endmodule

// File: rtl/hrd_page.sv
module hrd_page
  import hrd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_end,
  input  logic pagein,
  input  logic page_arg,
  input  logic modecmd,
  input  logic mode_arg,
  output logic mode_b,
  output logic page_vis,
  output logic page_sel
);
  mode_e mode_q, mode_d;
  logic  vis_q, vis_d, sel_q, sel_d;

  always_comb begin
    mode_d = mode_q;
    vis_d  = vis_q;
    sel_d  = sel_q;
    if (modecmd) begin
      mode_d = mode_e'(mode_arg);
      vis_d  = 1'b0;
    end else if (pagein) begin
      vis_d = 1'b1;
      sel_d = page_arg;
    end else if (acc_end && mode_q == MODE_A) begin
      vis_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_A;
      vis_q  <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      vis_q  <= vis_d;
      sel_q  <= sel_d;
    end
  end

  assign mode_b   = (mode_q == MODE_B);
  assign page_vis = vis_q;
  assign page_sel = sel_q;
endmodule

// File: rtl/hrd_irq.sv
module hrd_irq #(
  parameter int NSTAT = 3,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSTAT*DW-1:0] evt_i,
  input  logic                clr_en,
  input  logic [1:0]          clr_reg,
  input  logic [2:0]          clr_bit,
  input  logic [NSTAT-1:0]    mask_we,
  input  logic [DW-1:0]       mask_wd,
  output logic [NSTAT*DW-1:0] status_o,
  output logic                irq_o
);
  logic [NSTAT-1:0] hit;

  for (genvar g = 0; g < NSTAT; g++) begin : g_bank
    logic [DW-1:0] st_q, st_d, mk_q, mk_d, clr_vec;

    always_comb begin
      clr_vec = '0;
      if (clr_en && clr_reg == 2'(g)) clr_vec[clr_bit] = 1'b1;
      st_d = (st_q & ~clr_vec) | evt_i[g*DW +: DW];
      mk_d = mask_we[g] ? mask_wd : mk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
        mk_q <= '0;
      end else begin
        st_q <= st_d;
        mk_q <= mk_d;
      end
    end

    assign status_o[g*DW +: DW] = st_q;
    assign hit[g]               = |(st_q & mk_q);
  end

  assign irq_o = |hit;
endmodule

// File: rtl/hostreg_decoder.sv
module hostreg_decoder
  import hrd_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic                dack_n,
  input  logic [AW-1:0]       rs,
  input  logic [DW-1:0]       din,
  output logic [DW-1:0]       dout,
  output logic                int_o,
  input  logic [NSTAT*DW-1:0] evt_i,
  input  logic [DW-1:0]       rx_data_i,
  input  logic                rx_load_i,
  output logic [DW-1:0]       tx_data_o,
  output logic                tx_load_o
);
  logic          acc_end, acc_wr, acc_dma;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_data;
  logic          acc_cs_end, wr_commit, cs_wr, aux_wr;
  logic          pagein, modecmd, clr_en;
  logic          mode_b, page_vis, page_sel;
  logic [NSTAT-1:0]    mask_we;
  logic                tx_we, ext_we;
  logic [NSTAT*DW-1:0] status;
  logic [DW-1:0] rx_q, rx_d, tx_q, tx_d, ext_q, ext_d;
  logic          txl_q, txl_d;

  hrd_strobe #(.AW(AW), .DW(DW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .dack_n(dack_n), .rs(rs), .din(din), .end_o(acc_end), .wr_o(acc_wr),
    .dma_o(acc_dma), .addr_o(acc_addr), .data_o(acc_data)
  );

  always_comb begin
    acc_cs_end = acc_end & ~acc_dma;
    wr_commit  = acc_end & acc_wr;
    cs_wr      = wr_commit & ~acc_dma;
    aux_wr     = cs_wr & (acc_addr == AW'(OFF_AUX));
    pagein     = aux_wr & (acc_data[7:5] == OP_PAGE);
    modecmd    = aux_wr & (acc_data[7:5] == OP_MODE);
    clr_en     = aux_wr & (acc_data[7:5] == OP_CLR);
  end

  hrd_page u_page (
    .clk(clk), .rst_n(rst_n), .acc_end(acc_cs_end), .pagein(pagein),
    .page_arg(acc_data[0]), .modecmd(modecmd), .mode_arg(acc_data[0]),
    .mode_b(mode_b), .page_vis(page_vis), .page_sel(page_sel)
  );

  always_comb begin
    tx_we      = wr_commit & (acc_dma | (acc_addr == AW'(OFF_DATA)));
    mask_we    = '0;
    mask_we[0] = cs_wr & (acc_addr == AW'(OFF_ST0));
    mask_we[1] = cs_wr & (acc_addr == AW'(OFF_ST1)) & ~page_vis;
    mask_we[2] = cs_wr & (acc_addr == AW'(OFF_ST1)) & page_vis & ~page_sel;
    ext_we     = cs_wr & (((acc_addr == AW'(OFF_ST1)) & page_vis & page_sel) |
                          ((acc_addr == AW'(OFF_EXT)) & mode_b));
  end

  hrd_irq #(.NSTAT(NSTAT), .DW(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_en(clr_en),
    .clr_reg(acc_data[4:3]), .clr_bit(acc_data[2:0]), .mask_we(mask_we),
    .mask_wd(acc_data), .status_o(status), .irq_o(int_o)
  );

  always_comb begin
    rx_d  = rx_load_i ? rx_data_i : rx_q;
    tx_d  = tx_we ? acc_data : tx_q;
    ext_d = ext_we ? acc_data : ext_q;
    txl_d = tx_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      tx_q  <= '0;
      ext_q <= '0;
      txl_q <= 1'b0;
    end else begin
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      ext_q <= ext_d;
      txl_q <= txl_d;
    end
  end

  always_comb begin
    dout = '0;
    if (!rd_n && !dack_n) begin
      dout = rx_q;
    end else if (!rd_n && !cs_n) begin
      case (rs)
        AW'(OFF_DATA): dout = rx_q;
        AW'(OFF_ST0):  dout = status[0 +: DW];
        AW'(OFF_ST1):  dout = !page_vis ? status[DW +: DW] :
                              (page_sel ? ext_q : status[2*DW +: DW]);
        AW'(OFF_CTRL): dout = {{(DW-2){1'b0}}, page_vis, mode_b};
        AW'(OFF_EXT):  dout = mode_b ? ext_q : '0;
        default:       dout = '0;
      endcase
    end
  end

  assign tx_data_o = tx_q;
  assign tx_load_o = txl_q;
endmodule

// File: rtl/hrd_checker.sv
module hrd_checker #(
  parameter int NSTAT = 3,
  parameter int DW    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                int_o,
  input logic                tx_load_o,
  input logic                dack_n,
  input logic                rd_n,
  input logic [DW-1:0]       dout,
  input logic [DW-1:0]       rx_q,
  input logic [NSTAT*DW-1:0] status,
  input logic                clr_en,
  input logic                acc_cs_end,
  input logic                pagein,
  input logic                modecmd,
  input logic                mode_b,
  input logic                page_vis
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle: assert (!int_o && !tx_load_o && !page_vis && !mode_b);
    end
  end

  a_r2_txload_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |=> !tx_load_o);

  a_r3_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status) != '0) |->
      ($past(clr_en) && $countones($past(status) & ~status) == 1));

  a_r5_dma_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!dack_n && !rd_n) |-> (dout == rx_q));

  a_r7_pageout_a: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cs_end && !mode_b && !pagein && !modecmd) |=> !page_vis);

  a_r8_persist_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b && page_vis && !modecmd) |=> page_vis);
endmodule

bind hostreg_decoder hrd_checker #(.NSTAT(hrd_pkg::NSTAT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_o(int_o), .tx_load_o(tx_load_o),
  .dack_n(dack_n), .rd_n(rd_n), .dout(dout), .rx_q(rx_q), .status(status),
  .clr_en(clr_en), .acc_cs_end(acc_cs_end), .pagein(pagein),
  .modecmd(modecmd), .mode_b(mode_b), .page_vis(page_vis)
);

// File: tb/hostreg_decoder_tb.sv
module hostreg_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, rd_n, wr_n, dack_n, rx_load;
  logic [2:0]  rs;
  logic [7:0]  din, rx_data;
  logic [23:0] evt;
  logic [7:0]  dout, tx_data;
  logic        int_o, tx_load;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hostreg_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .dack_n(dack_n), .rs(rs), .din(din), .dout(dout), .int_o(int_o),
    .evt_i(evt), .rx_data_i(rx_data), .rx_load_i(rx_load),
    .tx_data_o(tx_data), .tx_load_o(tx_load)
  );

  // behavioural reference model
  logic [7:0] m_st [3];
  logic [7:0] m_mk [3];
  logic [7:0] clrv [3];
  logic [7:0] m_rx, m_tx, m_ext, m_d, e_dout;
  logic [2:0] m_a;
  bit m_modeb, m_pg, m_psel, m_txl, m_act, m_w, m_dma, m_now, e_int;

  task automatic cmp(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_mk[i] = 0; end
      m_rx = 0; m_tx = 0; m_ext = 0; m_d = 0; m_a = 0;
      m_modeb = 0; m_pg = 0; m_psel = 0; m_txl = 0; m_act = 0; m_w = 0; m_dma = 0;
    end else begin
      m_now = (!cs_n || !dack_n) && (!rd_n || !wr_n);
      for (int i = 0; i < 3; i++) clrv[i] = 0;
      m_txl = 0;
      if (m_act && !m_now) begin
        if (m_w) begin
          if (m_dma) begin m_tx = m_d; m_txl = 1; end
          else case (m_a)
            3'd0: begin m_tx = m_d; m_txl = 1; end
            3'd1: m_mk[0] = m_d;
            3'd2: if (!m_pg) m_mk[1] = m_d; else if (!m_psel) m_mk[2] = m_d; else m_ext = m_d;
            3'd6: if (m_modeb) m_ext = m_d;
            default: ;
          endcase
        end
        if (!m_dma) begin
          if (m_w && m_a == 5 && m_d[7:5] == 3'b010) begin m_pg = 1; m_psel = m_d[0]; end
          else if (m_w && m_a == 5 && m_d[7:5] == 3'b001) begin m_modeb = m_d[0]; m_pg = 0; end
          else if (!m_modeb) m_pg = 0;
          if (m_w && m_a == 5 && m_d[7:5] == 3'b100 && m_d[4:3] < 3)
            clrv[m_d[4:3]][m_d[2:0]] = 1'b1;
        end
      end
      for (int i = 0; i < 3; i++) m_st[i] = (m_st[i] & ~clrv[i]) | evt[i*8 +: 8];
      if (rx_load) m_rx = rx_data;
      if (m_now) begin m_a = rs; m_d = din; m_w = !wr_n; m_dma = !dack_n; end
      m_act = m_now;
    end
    #1;
    if (rst_n) begin
      e_dout = 0;
      if (!rd_n && !dack_n) e_dout = m_rx;
      else if (!rd_n && !cs_n) case (rs)
        3'd0: e_dout = m_rx;
        3'd1: e_dout = m_st[0];
        3'd2: e_dout = !m_pg ? m_st[1] : (m_psel ? m_ext : m_st[2]);
        3'd3: e_dout = {6'b0, m_pg, m_modeb};
        3'd6: e_dout = m_modeb ? m_ext : 8'h00;
        default: e_dout = 0;
      endcase
      e_int = |((m_st[0] & m_mk[0]) | (m_st[1] & m_mk[1]) | (m_st[2] & m_mk[2]));
      cmp("R2 model dout", dout, e_dout);
      cmp("R4 model int", int_o, e_int);
      cmp("R2 model tx_data", tx_data, m_tx);
      cmp("R2 model tx_load", tx_load, m_txl);
    end
  end

  task automatic hwr(input logic [2:0] a, input logic [7:0] v, input bit dma);
    @(negedge clk);
    rs = a; din = v; wr_n = 0;
    if (dma) dack_n = 0; else cs_n = 0;
    @(negedge clk);
    wr_n = 1; cs_n = 1; dack_n = 1;
  endtask

  task automatic hrd(input logic [2:0] a, input bit dma, output logic [7:0] v);
    @(negedge clk);
    rs = a; rd_n = 0;
    if (dma) dack_n = 0; else cs_n = 0;
    @(posedge clk); #2;
    v = dout;
    @(negedge clk);
    rd_n = 1; cs_n = 1; dack_n = 1;
  endtask

  task automatic pulse_evt(input int b);
    @(negedge clk); evt = 24'h0; evt[b] = 1'b1;
    @(negedge clk); evt = 24'h0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1; cs_n = 1; rd_n = 1; wr_n = 1; dack_n = 1;
    rs = 0; din = 0; evt = 0; rx_load = 0; rx_data = 0;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 int_o", int_o, 0);
    cmp("R1 tx_load", tx_load, 0);
    hrd(3'd3, 0, v); cmp("R1 ctrl", v, 8'h00);
    hrd(3'd1, 0, v); cmp("R1 status0", v, 8'h00);
    // R2 data-out write
    hwr(3'd0, 8'hA5, 0);
    @(negedge clk); cmp("R2 tx_data", tx_data, 8'hA5);
    // R3 / R4 static status and mask
    pulse_evt(2);
    cmp("R4 masked off", int_o, 0);
    hrd(3'd1, 0, v); cmp("R3 status read", v, 8'h04);
    hrd(3'd1, 0, v); cmp("R3 status kept", v, 8'h04);
    hwr(3'd1, 8'h01, 0);
    @(negedge clk); cmp("R4 other bit mask", int_o, 0);
    hwr(3'd1, 8'h04, 0);
    @(negedge clk); cmp("R4 unmasked", int_o, 1);
    hwr(3'd5, 8'h9A, 0);   // clear for nonexistent register 3
    hrd(3'd1, 0, v); cmp("R3 clear other reg", v, 8'h04);
    hwr(3'd5, 8'h82, 0);
    hrd(3'd1, 0, v); cmp("R3 cleared", v, 8'h00);
    cmp("R4 cleared int", int_o, 0);
    // R5 DMA
    @(negedge clk); rx_data = 8'h3C; rx_load = 1;
    @(negedge clk); rx_load = 0;
    rs = 3'd5;
    hrd(3'd5, 1, v); cmp("R5 dma read", v, 8'h3C);
    hwr(3'd3, 8'h77, 1);
    @(negedge clk); cmp("R5 dma write", tx_data, 8'h77);
    // R6 / R7 overlay in personality A
    pulse_evt(23);
    hwr(3'd5, 8'h40, 0);
    hrd(3'd2, 0, v); cmp("R6 overlay status2", v, 8'h80);
    hrd(3'd2, 0, v); cmp("R7 overlay withdrawn", v, 8'h00);
    hwr(3'd5, 8'h40, 0);
    hrd(3'd0, 1, v); cmp("R5 dma read in overlay", v, 8'h3C);
    hrd(3'd2, 0, v); cmp("R5 dma kept overlay", v, 8'h80);
    hwr(3'd5, 8'h40, 0);
    hwr(3'd2, 8'h80, 0);
    @(negedge clk); cmp("R6 mask2 write", int_o, 1);
    hwr(3'd5, 8'h97, 0);
    @(negedge clk); cmp("R3 clear status2", int_o, 0);
    hwr(3'd5, 8'h41, 0);
    hwr(3'd2, 8'h5A, 0);
    hwr(3'd5, 8'h41, 0);
    hrd(3'd2, 0, v); cmp("R6 ext overlay", v, 8'h5A);
    // R10 / R8 personality B
    hwr(3'd5, 8'h21, 0);
    hrd(3'd3, 0, v); cmp("R10 mode B", v, 8'h01);
    hwr(3'd5, 8'h41, 0);
    hrd(3'd2, 0, v); cmp("R8 overlay 1st", v, 8'h5A);
    hrd(3'd2, 0, v); cmp("R8 overlay persists", v, 8'h5A);
    hrd(3'd3, 0, v); cmp("R8 ctrl overlay", v, 8'h03);
    pulse_evt(16);
    hwr(3'd5, 8'h40, 0);
    hrd(3'd2, 0, v); cmp("R8 overlay replaced", v, 8'h01);
    hrd(3'd2, 0, v); cmp("R8 replaced persists", v, 8'h01);
    // R9 offset 6
    hwr(3'd6, 8'hC3, 0);
    hrd(3'd6, 0, v); cmp("R9 ext in B", v, 8'hC3);
    hwr(3'd5, 8'h20, 0);
    hrd(3'd3, 0, v); cmp("R10 mode A, overlay gone", v, 8'h00);
    hrd(3'd6, 0, v); cmp("R9 offset6 in A", v, 8'h00);
    hwr(3'd6, 8'h11, 0);
    hwr(3'd5, 8'h21, 0);
    hrd(3'd6, 0, v); cmp("R9 A write ignored", v, 8'hC3);
    // R11 unassigned offsets
    hrd(3'd4, 0, v); cmp("R11 offset4", v, 8'h00);
    hrd(3'd7, 0, v); cmp("R11 offset7", v, 8'h00);
    hrd(3'd5, 0, v); cmp("R11 offset5", v, 8'h00);
    // R8 reset returns to A
    hwr(3'd5, 8'h41, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    hrd(3'd3, 0, v); cmp("R8 reset to A", v, 8'h00);
    hrd(3'd6, 0, v); cmp("R1 ext after reset", v, 8'h00);
    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end
endmodule